// File: doc/BRIEF.md
# Fault-Injecting Dual-Port Word Memory

This block is a dual-port word memory intended to serve as a device under test for memory self-test controllers. Two ports, A and B, each carry their own enable, write enable, address, write data and read data, and both may access the array in the same clock cycle. Reads are synchronous: the word appears on the read data output one clock edge after the request. The read data then holds until the next read on that port.

A small set of fault slots can be loaded through a configuration interface. Each slot names a fault kind, a victim word and a victim bit, and has its own enable. A global injection input gates every slot at once. While injection is off, or no slot is enabled, the block behaves as a plain fault-free RAM. While a slot is active, accesses that touch its victim bit follow that slot's single-cell fault rule. The rule can change the stored bit, the returned bit, or both. The cell array is organised as rows of a configurable number of words each.

Top module: `fault_ram`

## Requirements
- R1: A port with enable high and write enable low reads; the addressed word is on its read data after the next rising clock edge and holds until that port reads again. With injection off, reads and writes behave as a plain RAM.
- R2: After reset every word reads 0, both read data outputs are 0 and every fault slot is disabled.
- R3: When both ports write the same word in one cycle, port A's data is stored. A read of a word that the other port writes in the same cycle returns the word's previous contents.
- R4: Kind code 0 (stuck-at-0) and code 1 (stuck-at-1) make the victim bit read as 0 or 1 on either port. While the slot is active the stored bit is forced to that value, whatever is written.
- R5: Kind code 2 blocks a write that would raise the victim bit from 0 to 1. Kind code 3 blocks a write that would lower it from 1 to 0. Writes in the other direction act normally.
- R6: Kind code 4 (read-destructive) inverts the stored victim bit on each read of the victim word, and the read returns the inverted value.
- R7: Kind code 5 (deceptive read-destructive) inverts the stored victim bit on each read, but the read returns the value held before that read.
- R8: Kind code 6 (incorrect read) leaves the stored bit unchanged and returns its complement.
- R9: Kind code 7 (random read) leaves the stored bit unchanged. The returned victim bit comes from an internal LFSR that is seeded at reset, and all other bits of the word read correctly.
- R10: Kind code 8 turns a victim bit that holds 1 into 0, and kind code 9 turns a victim bit that holds 0 into 1. The change happens once RETAIN_CYCLES cycles have passed with no write to the victim word, and a write restarts the count.
- R11: Several slots may be active at once on different victims, and each applies its own rule independently.
- R12: With the global injection input low, every slot is ignored even if enabled. Raising the input again reapplies the configured faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inj_en | input | 1 | Global fault injection enable |
| cfg_we | input | 1 | Load one fault slot this cycle |
| cfg_slot | input | SLOT_W | Slot index to load |
| cfg_kind | input | 4 | Fault kind code (0 to 9) |
| cfg_word | input | ADDR_W | Victim word address |
| cfg_bit | input | BIT_W | Victim bit position in the word |
| cfg_en | input | 1 | Slot enable value to load |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |

## Verification
The fault-rule assertions assume that only slot 0 is enabled when they judge a victim access, because a second slot on the same bit would be allowed to override the result. The plain-RAM assertions assume that injection is off. The random phase keeps injection low and draws addresses from a narrow range, so that same-word collisions on both ports happen often. Each directed fault case enables a single slot, except the one case that checks concurrent slots, and there the two victims sit in different words.

// File: rtl/fault_ram_pkg.sv
package fault_ram_pkg;

    localparam int KIND_W = 4;

    typedef enum logic [KIND_W-1:0] {
        FK_SA0      = 4'd0,
        FK_SA1      = 4'd1,
        FK_TF_RISE  = 4'd2,
        FK_TF_FALL  = 4'd3,
        FK_RDF      = 4'd4,
        FK_DRDF     = 4'd5,
        FK_IRF      = 4'd6,
        FK_RRF      = 4'd7,
        FK_DRF_ONE  = 4'd8,
        FK_DRF_ZERO = 4'd9
    } fault_kind_e;

endpackage

// File: rtl/fault_ram_cfg.sv
module fault_ram_cfg
    import fault_ram_pkg::*;
#(
    parameter int NUM_SLOTS = 2,
    parameter int ADDR_W    = 4,
    parameter int BIT_W     = 3,
    parameter int SLOT_W    = 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_we,
    input  logic [SLOT_W-1:0]                   cfg_slot,
    input  logic [KIND_W-1:0]                   cfg_kind,
    input  logic [ADDR_W-1:0]                   cfg_word,
    input  logic [BIT_W-1:0]                    cfg_bit,
    input  logic                                cfg_en,
    output logic [NUM_SLOTS-1:0][KIND_W-1:0]    slot_kind,
    output logic [NUM_SLOTS-1:0][ADDR_W-1:0]    slot_word,
    output logic [NUM_SLOTS-1:0][BIT_W-1:0]     slot_bit,
    output logic [NUM_SLOTS-1:0]                slot_en
);

    typedef struct packed {
        logic [NUM_SLOTS-1:0][KIND_W-1:0] kind;
        logic [NUM_SLOTS-1:0][ADDR_W-1:0] word;
        logic [NUM_SLOTS-1:0][BIT_W-1:0]  bitpos;
        logic [NUM_SLOTS-1:0]             en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we && (int'(cfg_slot) < NUM_SLOTS)) begin
            cfg_d.kind[cfg_slot]   = cfg_kind;
            cfg_d.word[cfg_slot]   = cfg_word;
            cfg_d.bitpos[cfg_slot] = cfg_bit;
            cfg_d.en[cfg_slot]     = cfg_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign slot_kind = cfg_q.kind;
    assign slot_word = cfg_q.word;
    assign slot_bit  = cfg_q.bitpos;
    assign slot_en   = cfg_q.en;

endmodule

// File: rtl/fault_ram_retain.sv
module fault_ram_retain #(
    parameter int LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic touch,
    output logic expired
);

    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!arm || touch)                  cnt_d = '0;
        else if (cnt_q != CNT_W'(LIMIT))    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = arm && (cnt_q == CNT_W'(LIMIT));

endmodule

// File: rtl/fault_ram_lfsr.sv
module fault_ram_lfsr #(
    parameter int               W    = 16,
    parameter logic [W-1:0]     SEED = 16'hACE1,
    parameter logic [W-1:0]     TAPS = 16'hB400
) (
    input  logic clk,
    input  logic rst_n,
    output logic rnd_a,
    output logic rnd_b
);

    logic [W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = {1'b0, lfsr_q[W-1:1]};
        if (lfsr_q[0]) lfsr_d = lfsr_d ^ TAPS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign rnd_a = lfsr_q[0];
    assign rnd_b = lfsr_q[W-1];

endmodule

// File: rtl/fault_ram.sv
module fault_ram
    import fault_ram_pkg::*;
#(
    parameter int ADDR_W        = 4,
    parameter int DATA_W        = 8,
    parameter int WORDS_PER_ROW = 4,
    parameter int NUM_SLOTS     = 2,
    parameter int RETAIN_CYCLES = 20,
    parameter int LFSR_W        = 16,
    localparam int BIT_W        = (DATA_W > 1) ? $clog2(DATA_W) : 1,
    localparam int SLOT_W       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inj_en,
    input  logic                cfg_we,
    input  logic [SLOT_W-1:0]   cfg_slot,
    input  logic [3:0]          cfg_kind,
    input  logic [ADDR_W-1:0]   cfg_word,
    input  logic [BIT_W-1:0]    cfg_bit,
    input  logic                cfg_en,
    input  logic                a_en,
    input  logic                a_we,
    input  logic [ADDR_W-1:0]   a_addr,
    input  logic [DATA_W-1:0]   a_wdata,
    output logic [DATA_W-1:0]   a_rdata,
    input  logic                b_en,
    input  logic                b_we,
    input  logic [ADDR_W-1:0]   b_addr,
    input  logic [DATA_W-1:0]   b_wdata,
    output logic [DATA_W-1:0]   b_rdata
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int COL_W = $clog2(WORDS_PER_ROW);
    localparam int ROWS  = DEPTH / WORDS_PER_ROW;
    localparam int ROW_W = ADDR_W - COL_W;

    typedef logic [ROWS-1:0][WORDS_PER_ROW-1:0][DATA_W-1:0] array_t;

    typedef struct packed {
        array_t            mem;
        logic [DATA_W-1:0] rd_a;
        logic [DATA_W-1:0] rd_b;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SLOTS-1:0][KIND_W-1:0] slot_kind;
    logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_word;
    logic [NUM_SLOTS-1:0][BIT_W-1:0]  slot_bit;
    logic [NUM_SLOTS-1:0]             slot_en;
    logic [NUM_SLOTS-1:0]             slot_act;
    logic [NUM_SLOTS-1:0]             slot_wr;
    logic [NUM_SLOTS-1:0]             drf_exp;
    logic                             rnd_a, rnd_b;
    logic                             a_wr, a_rd, b_wr, b_rd;

    assign a_wr = a_en && a_we;
    assign a_rd = a_en && !a_we;
    assign b_wr = b_en && b_we;
    assign b_rd = b_en && !b_we;

    fault_ram_cfg #(
        .NUM_SLOTS (NUM_SLOTS),
        .ADDR_W    (ADDR_W),
        .BIT_W     (BIT_W),
        .SLOT_W    (SLOT_W)
    ) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_slot  (cfg_slot),
        .cfg_kind  (cfg_kind),
        .cfg_word  (cfg_word),
        .cfg_bit   (cfg_bit),
        .cfg_en    (cfg_en),
        .slot_kind (slot_kind),
        .slot_word (slot_word),
        .slot_bit  (slot_bit),
        .slot_en   (slot_en)
    );

    fault_ram_lfsr #(
        .W     (LFSR_W),
        .SEED  (LFSR_W'(16'hACE1)),
        .TAPS  (LFSR_W'(16'hB400))
    ) i_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd_a (rnd_a),
        .rnd_b (rnd_b)
    );

    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            slot_act[i] = inj_en && slot_en[i];
            slot_wr[i]  = (a_wr && (a_addr == slot_word[i])) ||
                          (b_wr && (b_addr == slot_word[i]));
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_retain
        fault_ram_retain #(
            .LIMIT   (RETAIN_CYCLES)
        ) i_retain (
            .clk     (clk),
            .rst_n   (rst_n),
            .arm     (slot_act[g] &&
                      ((slot_kind[g] == FK_DRF_ONE) || (slot_kind[g] == FK_DRF_ZERO))),
            .touch   (slot_wr[g]),
            .expired (drf_exp[g])
        );
    end

    logic [DATA_W-1:0] ra, rb;
    logic [ROW_W-1:0]  vr;
    logic [COL_W-1:0]  vc;
    logic [BIT_W-1:0]  bp;
    logic              old_bit, new_bit, hit_a, hit_b;

    always_comb begin
        st_d    = st_q;
        ra      = st_q.mem[a_addr[ADDR_W-1:COL_W]][a_addr[COL_W-1:0]];
        rb      = st_q.mem[b_addr[ADDR_W-1:COL_W]][b_addr[COL_W-1:0]];
        vr      = '0;
        vc      = '0;
        bp      = '0;
        old_bit = 1'b0;
        new_bit = 1'b0;
        hit_a   = 1'b0;
        hit_b   = 1'b0;

        // port B first so that port A wins a same-word write
        if (b_wr) st_d.mem[b_addr[ADDR_W-1:COL_W]][b_addr[COL_W-1:0]] = b_wdata;
        if (a_wr) st_d.mem[a_addr[ADDR_W-1:COL_W]][a_addr[COL_W-1:0]] = a_wdata;

        for (int i = 0; i < NUM_SLOTS; i++) begin
            vr      = slot_word[i][ADDR_W-1:COL_W];
            vc      = slot_word[i][COL_W-1:0];
            bp      = slot_bit[i];
            old_bit = st_q.mem[vr][vc][bp];
            new_bit = st_d.mem[vr][vc][bp];
            hit_a   = a_rd && (a_addr == slot_word[i]);
            hit_b   = b_rd && (b_addr == slot_word[i]);
            if (slot_act[i]) begin
                case (fault_kind_e'(slot_kind[i]))
                    FK_SA0, FK_SA1: begin
                        st_d.mem[vr][vc][bp] = slot_kind[i][0];
                        if (hit_a) ra[bp] = slot_kind[i][0];
                        if (hit_b) rb[bp] = slot_kind[i][0];
                    end
                    FK_TF_RISE: begin
                        if (slot_wr[i] && !old_bit && new_bit) st_d.mem[vr][vc][bp] = 1'b0;
                    end
                    FK_TF_FALL: begin
                        if (slot_wr[i] && old_bit && !new_bit) st_d.mem[vr][vc][bp] = 1'b1;
                    end
                    FK_RDF: begin
                        if ((hit_a || hit_b) && !slot_wr[i]) st_d.mem[vr][vc][bp] = !old_bit;
                        if (hit_a) ra[bp] = !old_bit;
                        if (hit_b) rb[bp] = !old_bit;
                    end
                    FK_DRDF: begin
                        if ((hit_a || hit_b) && !slot_wr[i]) st_d.mem[vr][vc][bp] = !old_bit;
                    end
                    FK_IRF: begin
                        if (hit_a) ra[bp] = !old_bit;
                        if (hit_b) rb[bp] = !old_bit;
                    end
                    FK_RRF: begin
                        if (hit_a) ra[bp] = rnd_a;
                        if (hit_b) rb[bp] = rnd_b;
                    end
                    FK_DRF_ONE: begin
                        if (drf_exp[i] && !slot_wr[i] && old_bit) st_d.mem[vr][vc][bp] = 1'b0;
                    end
                    FK_DRF_ZERO: begin
                        if (drf_exp[i] && !slot_wr[i] && !old_bit) st_d.mem[vr][vc][bp] = 1'b1;
                    end
                    default: ;
                endcase
            end
        end

        if (a_rd) st_d.rd_a = ra;
        if (b_rd) st_d.rd_b = rb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_rdata = st_q.rd_a;
    assign b_rdata = st_q.rd_b;

endmodule

// File: rtl/fault_ram_chk.sv
module fault_ram_chk #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int NUM_SLOTS = 2,
    parameter int BIT_W     = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       inj_en,
    input  logic                       a_en,
    input  logic                       a_we,
    input  logic [ADDR_W-1:0]          a_addr,
    input  logic [DATA_W-1:0]          a_wdata,
    input  logic [DATA_W-1:0]          a_rdata,
    input  logic                       b_en,
    input  logic                       b_we,
    input  logic [ADDR_W-1:0]          b_addr,
    input  logic [NUM_SLOTS-1:0]       slot_en,
    input  logic [3:0]                 s0_kind,
    input  logic [ADDR_W-1:0]          s0_word,
    input  logic [BIT_W-1:0]           s0_bit,
    input  logic [(1<<ADDR_W)*DATA_W-1:0] mem_flat
);

    logic [DATA_W-1:0] word_at_a;
    logic [DATA_W-1:0] word_at_prev_a;
    logic              victim;
    logic              only_s0;
    logic              a_hits_victim;
    logic [ADDR_W-1:0] prev_a_addr;
    logic [BIT_W-1:0]  prev_bit;

    assign word_at_a      = mem_flat[int'(a_addr)*DATA_W +: DATA_W];
    assign word_at_prev_a = mem_flat[int'(prev_a_addr)*DATA_W +: DATA_W];
    assign victim         = mem_flat[int'(s0_word)*DATA_W + int'(s0_bit)];
    assign only_s0        = inj_en && (slot_en == NUM_SLOTS'(1));
    assign a_hits_victim  = a_en && !a_we && (a_addr == s0_word);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_a_addr <= '0;
            prev_bit    <= '0;
        end else begin
            prev_a_addr <= a_addr;
            prev_bit    <= s0_bit;
        end
    end

    assert_fault_free_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!inj_en && a_en && !a_we) |=> (a_rdata == $past(word_at_a)));

    assert_port_a_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!inj_en && a_en && a_we && b_en && b_we && (a_addr == b_addr))
        |=> (word_at_prev_a == $past(a_wdata)));

    assert_stuck_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (only_s0 && (s0_kind[3:1] == 3'd0) && a_hits_victim)
        |=> (a_rdata[prev_bit] == $past(s0_kind[0])));

    assert_read_flips_cell_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (only_s0 && (s0_kind == 4'd4) && a_hits_victim &&
         !(b_en && b_we && (b_addr == s0_word)))
        |=> (victim == !$past(victim)));

    assert_incorrect_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (only_s0 && (s0_kind == 4'd6) && a_hits_victim)
        |=> (a_rdata[prev_bit] == !$past(victim)));

endmodule

bind fault_ram fault_ram_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_SLOTS (NUM_SLOTS),
    .BIT_W     (BIT_W)
) i_fault_ram_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .inj_en    (inj_en),
    .a_en      (a_en),
    .a_we      (a_we),
    .a_addr    (a_addr),
    .a_wdata   (a_wdata),
    .a_rdata   (a_rdata),
    .b_en      (b_en),
    .b_we      (b_we),
    .b_addr    (b_addr),
    .slot_en   (slot_en),
    .s0_kind   (slot_kind[0]),
    .s0_word   (slot_word[0]),
    .s0_bit    (slot_bit[0]),
    .mem_flat  (st_q.mem)
);

// File: tb/test_fault_ram.sv
module test_fault_ram;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              inj_en = 1'b0;
    logic              cfg_we = 1'b0;
    logic [0:0]        cfg_slot = '0;
    logic [3:0]        cfg_kind = '0;
    logic [ADDR_W-1:0] cfg_word = '0;
    logic [2:0]        cfg_bit = '0;
    logic              cfg_en = 1'b0;
    logic              a_en = 1'b0, a_we = 1'b0;
    logic [ADDR_W-1:0] a_addr = '0;
    logic [DATA_W-1:0] a_wdata = '0;
    logic [DATA_W-1:0] a_rdata;
    logic              b_en = 1'b0, b_we = 1'b0;
    logic [ADDR_W-1:0] b_addr = '0;
    logic [DATA_W-1:0] b_wdata = '0;
    logic [DATA_W-1:0] b_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [DATA_W-1:0] model [1<<ADDR_W];

    always #4ns clk = ~clk;

    fault_ram i_fault_ram (
        .clk(clk), .rst_n(rst_n), .inj_en(inj_en),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_kind(cfg_kind),
        .cfg_word(cfg_word), .cfg_bit(cfg_bit), .cfg_en(cfg_en),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp,
                         input logic [7:0] mask = 8'hFF);
        checks++;
        if ((act & mask) !== (exp & mask)) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h (mask %02h)", req, act, exp, mask);
        end
    endtask

    task automatic op(input logic ae, input logic aw, input logic [3:0] aa, input logic [7:0] ad,
                      input logic be, input logic bw, input logic [3:0] ba, input logic [7:0] bd);
        a_en = ae; a_we = aw; a_addr = aa; a_wdata = ad;
        b_en = be; b_we = bw; b_addr = ba; b_wdata = bd;
        @(negedge clk);
        a_en = 1'b0; a_we = 1'b0; b_en = 1'b0; b_we = 1'b0;
    endtask

    task automatic wr_a(input logic [3:0] ad, input logic [7:0] d);
        op(1, 1, ad, d, 0, 0, 0, 0);
    endtask

    task automatic rd_a(input logic [3:0] ad, output logic [7:0] d);
        op(1, 0, ad, 0, 0, 0, 0, 0);
        d = a_rdata;
    endtask

    task automatic rd_b(input logic [3:0] ad, output logic [7:0] d);
        op(0, 0, 0, 0, 1, 0, ad, 0);
        d = b_rdata;
    endtask

    task automatic cfg(input int slot, input int kind, input logic [3:0] w,
                       input int b, input logic en);
        cfg_we = 1'b1; cfg_slot = 1'(slot); cfg_kind = 4'(kind);
        cfg_word = w; cfg_bit = 3'(b); cfg_en = en;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] exp_a, exp_b;
        logic       rda, rdb;
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) model[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        check("R2 a_rdata", a_rdata, 8'h00);
        check("R2 b_rdata", b_rdata, 8'h00);
        rd_a(4'd9, d);  check("R2 word9", d, 8'h00);
        rd_b(4'd15, d); check("R2 word15", d, 8'h00);

        // R1 / R3 constrained random with injection off
        for (int n = 0; n < 400; n++) begin
            logic ae, aw, be, bw;
            logic [3:0] aa, ba;
            logic [7:0] ad, bd;
            ae = 1'($urandom_range(0, 1)); aw = 1'($urandom_range(0, 1));
            be = 1'($urandom_range(0, 1)); bw = 1'($urandom_range(0, 1));
            aa = 4'($urandom_range(0, 3)); ba = 4'($urandom_range(0, 3));
            ad = 8'($urandom); bd = 8'($urandom);
            rda = ae && !aw; rdb = be && !bw;
            exp_a = model[aa]; exp_b = model[ba];
            if (be && bw) model[ba] = bd;
            if (ae && aw) model[aa] = ad;
            op(ae, aw, aa, ad, be, bw, ba, bd);
            if (rda) check("R1 random port A (R3 collisions)", a_rdata, exp_a);
            if (rdb) check("R1 random port B (R3 collisions)", b_rdata, exp_b);
        end

        // R3 directed: both write same word, A wins
        op(1, 1, 4'd6, 8'h11, 1, 1, 4'd6, 8'h22);
        rd_b(4'd6, d); check("R3 port A wins", d, 8'h11);
        // R3 read during other port's write returns old
        wr_a(4'd7, 8'h33);
        op(1, 0, 4'd7, 8'h00, 1, 1, 4'd7, 8'h44);
        check("R3 read old data", a_rdata, 8'h33);
        rd_a(4'd7, d); check("R3 new data after", d, 8'h44);
        // R1 read data holds
        idle(3); check("R1 read data held", a_rdata, 8'h44);

        inj_en = 1'b1;

        // R4 stuck-at
        cfg(0, 0, 4'd13, 2, 1);
        wr_a(4'd13, 8'hFF);
        rd_a(4'd13, d); check("R4 stuck-at-0 port A", d, 8'hFB);
        rd_b(4'd13, d); check("R4 stuck-at-0 port B", d, 8'hFB);
        cfg(0, 1, 4'd13, 5, 1);
        wr_a(4'd13, 8'h00);
        rd_a(4'd13, d); check("R4 stuck-at-1", d, 8'h20);
        cfg(0, 1, 4'd13, 5, 0);
        rd_a(4'd13, d); check("R4 stored bit forced", d, 8'h20);

        // R5 transition
        cfg(0, 2, 4'd12, 4, 1);
        wr_a(4'd12, 8'h00); wr_a(4'd12, 8'h10);
        rd_a(4'd12, d); check("R5 rise blocked", d, 8'h00);
        cfg(0, 3, 4'd12, 4, 1);
        wr_a(4'd12, 8'hFF);
        rd_a(4'd12, d); check("R5 rise allowed under fall fault", d, 8'hFF);
        wr_a(4'd12, 8'h00);
        rd_b(4'd12, d); check("R5 fall blocked", d, 8'h10);
        cfg(0, 3, 4'd12, 4, 0);

        // R6 read destructive
        cfg(0, 4, 4'd8, 0, 1);
        wr_a(4'd8, 8'h00);
        rd_a(4'd8, d); check("R6 first read", d, 8'h01);
        rd_a(4'd8, d); check("R6 second read", d, 8'h00);
        rd_a(4'd8, d); check("R6 third read", d, 8'h01);
        cfg(0, 4, 4'd8, 0, 0);
        rd_a(4'd8, d); check("R6 stored flipped", d, 8'h01);

        // R7 deceptive read destructive
        cfg(0, 5, 4'd9, 7, 1);
        wr_a(4'd9, 8'h00);
        rd_a(4'd9, d); check("R7 first read correct", d, 8'h00);
        rd_a(4'd9, d); check("R7 second read sees flip", d, 8'h80);
        rd_a(4'd9, d); check("R7 third read", d, 8'h00);
        cfg(0, 5, 4'd9, 7, 0);
        rd_a(4'd9, d); check("R7 stored flipped", d, 8'h80);

        // R8 incorrect read
        cfg(0, 6, 4'd10, 1, 1);
        wr_a(4'd10, 8'h0F);
        rd_a(4'd10, d); check("R8 complement", d, 8'h0D);
        rd_b(4'd10, d); check("R8 complement again", d, 8'h0D);
        cfg(0, 6, 4'd10, 1, 0);
        rd_a(4'd10, d); check("R8 stored unchanged", d, 8'h0F);

        // R9 random read
        cfg(0, 7, 4'd11, 3, 1);
        wr_a(4'd11, 8'h55);
        for (int k = 0; k < 6; k++) begin
            rd_a(4'd11, d); check("R9 other bits correct", d, 8'h55, 8'hF7);
        end
        cfg(0, 7, 4'd11, 3, 0);
        rd_a(4'd11, d); check("R9 stored unchanged", d, 8'h55);

        // R10 data retention
        cfg(0, 8, 4'd14, 0, 1);
        wr_a(4'd14, 8'h01);
        idle(2);
        rd_a(4'd14, d); check("R10 ones kept early", d, 8'h01);
        idle(30);
        rd_a(4'd14, d); check("R10 ones decayed", d, 8'h00);
        cfg(0, 9, 4'd15, 6, 1);
        wr_a(4'd15, 8'h00);
        idle(2);
        rd_a(4'd15, d); check("R10 zeros kept early", d, 8'h00);
        idle(30);
        rd_a(4'd15, d); check("R10 zeros decayed", d, 8'h40);
        cfg(0, 9, 4'd15, 6, 0);

        // R11 two slots
        cfg(0, 1, 4'd2, 0, 1);
        cfg(1, 6, 4'd3, 7, 1);
        wr_a(4'd2, 8'h00); wr_a(4'd3, 8'h00);
        rd_a(4'd2, d); check("R11 slot0", d, 8'h01);
        rd_b(4'd3, d); check("R11 slot1", d, 8'h80);
        cfg(1, 6, 4'd3, 7, 0);

        // R12 global gate
        cfg(0, 0, 4'd5, 0, 1);
        inj_en = 1'b0;
        wr_a(4'd5, 8'hFF);
        rd_a(4'd5, d); check("R12 gate off ignores slot", d, 8'hFF);
        inj_en = 1'b1;
        rd_a(4'd5, d); check("R12 gate on reapplies", d, 8'hFE);
        inj_en = 1'b0;
        rd_a(4'd5, d); check("R12 stored forced while on", d, 8'hFE);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule